// File: doc/BRIEF.md
# Key-Guarded System Configuration Register Bank

This block is a small bank of system control registers reached over a simple single-cycle register bus. Two of its registers, the device configuration word and the clock divider word, are guarded. Software may change them only right after it writes a key value to the lock register. A key write arms the bank for exactly one access. If that access is a write to a guarded register, the write takes effect. Any other access spends the arming without effect.

A guarded write that arrives while the bank is locked is dropped, and a sticky violation flag records it. The bank also holds a read-only identity word. Its top field carries the chip revision, taken from a parameter, and software recovers it with a mask and a shift. Bit 31 of the device configuration word is a software reset bit. When a guarded write takes this bit from 1 to 0, the bank raises a one-cycle reset request for the system reset logic.

Register word addresses on `bus_addr` are: 0 lock, 1 device configuration, 2 identity, 3 clock divider, 4 status. An access is one cycle with `bus_sel` high. Read data appears on `bus_rdata` in the cycle after the read access.

Top module: `syscfg_lockbank`

## Requirements
- R1: After reset the bank is locked, the device configuration word reads DEVCFG_INIT (default 0x000000E0, the port-select bits that pick GPIO use), the clock divider reads 0, the status word reads 0 and `rst_req` is low.
- R2: A write of exactly 0x000000AA to address 0 arms the bank. A read of address 0 returns 1 in bit 0 while the bank is armed and 0 while it is locked, and all other bits read 0.
- R3: An armed write to address 1 or 3 updates that register, and the bank locks again afterwards. A second guarded write with no new key is dropped. A repeated key write keeps the bank armed.
- R4: A guarded write while the bank is locked leaves the register unchanged and sets status bit 0. That bit stays set until a write to address 4 with bit 0 equal to 1 clears it.
- R5: Any access other than a key write spends the arming. This covers any read (including a read of address 0, which still returns 1), a write of a non-key value to address 0, and a write to address 2 or 4.
- R6: Address 2 is read-only. It reads REV_VALUE (default 5) in bits 31:28 and 0 in all other bits, and writes to it change nothing and do not set the violation flag.
- R7: `rst_req` is high for exactly the one cycle that follows an accepted device configuration write that changes bit 31 from 1 to 0. Writes that set bit 31, or that keep it at 0, raise no request.
- R8: Read data appears on `bus_rdata` in the cycle after the read access. The clock divider keeps only its low CLKDIV_W (default 16) bits, and unmapped addresses 5 to 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
A wrong arm state shows up at the ports within two accesses. Either a guarded write lands that should have been dropped, or a legal one is lost, and the read that follows exposes the result. The read of address 0 and the violation flag in status bit 0 show whether the bank is armed and whether writes were dropped. A reset-bit edge detector that fires late, fires twice, or fires on the wrong transition is visible on `rst_req` in the cycle right after the write edge, so the bench samples that cycle and the next.

// File: rtl/syscfg_pkg.sv
package syscfg_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_LOCK    = 3'd0,
    A_DEVCFG  = 3'd1,
    A_IDENT   = 3'd2,
    A_CLKDIV  = 3'd3,
    A_STATUS  = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/syscfg_keylock.sv
module syscfg_keylock #(
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] KEY = 'hAA
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc,
  input  logic              wr,
  input  logic              is_lock_addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              armed
);
  // every access consumes the arm; only a key write re-arms
  always_ff @(posedge clk) begin
    if (rst)      armed <= 1'b0;
    else if (acc) armed <= wr && is_lock_addr && (wdata == KEY);
  end

  // R2: the bank can only be armed right after a write to the lock address
  assert_arm_source_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(armed) |-> $past(acc && wr && is_lock_addr));

  // R5: an access other than a lock write leaves the bank locked
  assert_spent_R5: assert property (@(posedge clk) disable iff (rst)
    (acc && !is_lock_addr) |=> !armed);
endmodule

// File: rtl/syscfg_guarded_reg.sv
module syscfg_guarded_reg #(
  parameter int W = 32,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hit,
  input  logic         armed,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q,
  output logic         blocked
);
  assign blocked = hit && !armed;

  always_ff @(posedge clk) begin
    if (rst)              q <= INIT;
    else if (hit && armed) q <= wdata;
  end

  // R4: the value only moves after an armed write
  assert_guard_R4: assert property (@(posedge clk) disable iff (rst)
    (q != $past(q)) |-> $past(hit && armed));

  // R3: an armed write lands its data
  assert_accept_R3: assert property (@(posedge clk) disable iff (rst)
    (hit && armed) |=> (q == $past(wdata)));
endmodule

// File: rtl/syscfg_swrst_edge.sv
module syscfg_swrst_edge (
  input  logic clk,
  input  logic rst,
  input  logic accept,
  input  logic bit_q,
  input  logic bit_new,
  output logic rst_req
);
  always_ff @(posedge clk) begin
    if (rst) rst_req <= 1'b0;
    else     rst_req <= accept && bit_q && !bit_new;
  end

  // R7: a request is a single cycle wide
  assert_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> !rst_req);

  // R7: a request follows a 1-to-0 change of the reset bit
  assert_fall_R7: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> ($past(bit_q) && !bit_q));
endmodule

// File: rtl/syscfg_lockbank.sv
module syscfg_lockbank #(
  parameter int DATA_W   = 32,
  parameter logic [DATA_W-1:0] KEY = 'hAA,
  parameter logic [DATA_W-1:0] DEVCFG_INIT = 'hE0,
  parameter int SWRST_BIT = 31,
  parameter int CLKDIV_W  = 16,
  parameter logic [CLKDIV_W-1:0] CLKDIV_INIT = '0,
  parameter int REV_W    = 4,
  parameter int REV_LSB  = 28,
  parameter logic [REV_W-1:0] REV_VALUE = 4'h5
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       bus_sel,
  input  logic                       bus_wr,
  input  logic [syscfg_pkg::ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0]          bus_wdata,
  output logic [DATA_W-1:0]          bus_rdata,
  output logic                       rst_req
);
  import syscfg_pkg::*;

  localparam logic [DATA_W-1:0] IDENT_WORD =
    DATA_W'({REV_VALUE}) << REV_LSB;

  logic armed;
  logic hit_dev, hit_clk, blk_dev, blk_clk;
  logic clr_viol, viol;
  logic [DATA_W-1:0]   devcfg_q;
  logic [CLKDIV_W-1:0] clkdiv_q;

  assign hit_dev  = bus_sel && bus_wr && (bus_addr == A_DEVCFG);
  assign hit_clk  = bus_sel && bus_wr && (bus_addr == A_CLKDIV);
  assign clr_viol = bus_sel && bus_wr && (bus_addr == A_STATUS) && bus_wdata[0];

  syscfg_keylock #(.DATA_W(DATA_W), .KEY(KEY)) u_lock (
    .clk(clk), .rst(rst), .acc(bus_sel), .wr(bus_wr),
    .is_lock_addr(bus_addr == A_LOCK), .wdata(bus_wdata), .armed(armed));

  syscfg_guarded_reg #(.W(DATA_W), .INIT(DEVCFG_INIT)) u_devcfg (
    .clk(clk), .rst(rst), .hit(hit_dev), .armed(armed),
    .wdata(bus_wdata), .q(devcfg_q), .blocked(blk_dev));

  syscfg_guarded_reg #(.W(CLKDIV_W), .INIT(CLKDIV_INIT)) u_clkdiv (
    .clk(clk), .rst(rst), .hit(hit_clk), .armed(armed),
    .wdata(bus_wdata[CLKDIV_W-1:0]), .q(clkdiv_q), .blocked(blk_clk));

  syscfg_swrst_edge u_swrst (
    .clk(clk), .rst(rst), .accept(hit_dev && armed),
    .bit_q(devcfg_q[SWRST_BIT]), .bit_new(bus_wdata[SWRST_BIT]),
    .rst_req(rst_req));

  always_ff @(posedge clk) begin
    if (rst)                   viol <= 1'b0;
    else if (blk_dev || blk_clk) viol <= 1'b1;
    else if (clr_viol)         viol <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_sel && !bus_wr) begin
      case (bus_addr)
        A_LOCK:   bus_rdata <= DATA_W'(armed);
        A_DEVCFG: bus_rdata <= devcfg_q;
        A_IDENT:  bus_rdata <= IDENT_WORD;
        A_CLKDIV: bus_rdata <= DATA_W'(clkdiv_q);
        A_STATUS: bus_rdata <= DATA_W'(viol);
        default:  bus_rdata <= '0;
      endcase
    end
  end

  // R4: the violation flag holds until an explicit clear
  assert_viol_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    (viol && !clr_viol) |=> viol);

  // R6: the identity word never changes
  assert_ident_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_wr && bus_addr == A_IDENT) |=> (bus_rdata == IDENT_WORD));
endmodule

// File: tb/tb_syscfg_lockbank.sv
module tb_syscfg_lockbank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rst_req;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam logic [31:0] KEYV = 32'hAA;

  always #2.5 clk = ~clk;

  syscfg_lockbank dut (.clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rst_req(rst_req));

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input bit w, input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = w; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    access(1'b0, a, 32'h0);
    d = bus_rdata;
  endtask

  task automatic expect_rd(input logic [2:0] a, input logic [31:0] exp, input string req);
    logic [31:0] d;
    rd(a, d);
    check(d === exp, req, d, exp);
  endtask

  task automatic t_reset;
    check(rst_req === 1'b0, "R1 rst_req idle", 32'(rst_req), 0);
    expect_rd(3'd0, 32'h0, "R1 lock reads locked");
    expect_rd(3'd1, 32'hE0, "R1 devcfg init");
    expect_rd(3'd3, 32'h0, "R1 clkdiv init");
    expect_rd(3'd4, 32'h0, "R1 status clear");
  endtask

  task automatic t_arm_read;
    access(1'b1, 3'd0, KEYV);
    expect_rd(3'd0, 32'h1, "R2 lock reads armed");
    expect_rd(3'd0, 32'h0, "R5 read of lock spends arm");
  endtask

  task automatic t_one_shot;
    access(1'b1, 3'd0, KEYV);
    access(1'b1, 3'd3, 32'h0000_1234);
    expect_rd(3'd3, 32'h1234, "R3 armed write lands");
    access(1'b1, 3'd3, 32'h0000_5555);
    expect_rd(3'd3, 32'h1234, "R3 second write dropped");
    expect_rd(3'd4, 32'h1, "R4 violation flagged");
    expect_rd(3'd4, 32'h1, "R4 violation sticky");
    access(1'b1, 3'd4, 32'h0);
    expect_rd(3'd4, 32'h1, "R4 clear needs bit0");
    access(1'b1, 3'd4, 32'h1);
    expect_rd(3'd4, 32'h0, "R4 violation cleared");
  endtask

  task automatic t_locked_write;
    access(1'b1, 3'd1, 32'h0000_0011);
    expect_rd(3'd1, 32'hE0, "R4 locked devcfg write dropped");
    expect_rd(3'd4, 32'h1, "R4 locked write flags");
    access(1'b1, 3'd4, 32'h1);
  endtask

  task automatic t_relock;
    access(1'b1, 3'd0, KEYV);
    expect_rd(3'd1, 32'hE0, "R5 read before write");
    access(1'b1, 3'd3, 32'h0000_0001);
    expect_rd(3'd3, 32'h1234, "R5 read spends arm");
    access(1'b1, 3'd0, KEYV);
    access(1'b1, 3'd0, 32'h55);
    access(1'b1, 3'd3, 32'h0000_0002);
    expect_rd(3'd3, 32'h1234, "R5 non-key lock write relocks");
    access(1'b1, 3'd0, KEYV);
    access(1'b1, 3'd0, 32'h1AA);
    expect_rd(3'd0, 32'h0, "R2 only exact key arms");
    access(1'b1, 3'd0, KEYV);
    access(1'b1, 3'd2, 32'hFFFF_FFFF);
    access(1'b1, 3'd3, 32'h0000_0003);
    expect_rd(3'd3, 32'h1234, "R5 ident write relocks");
    access(1'b1, 3'd4, 32'h1);
    access(1'b1, 3'd0, KEYV);
    access(1'b1, 3'd0, KEYV);
    access(1'b1, 3'd3, 32'hFFFF_ABCD);
    expect_rd(3'd3, 32'h0000_ABCD, "R3 repeated key keeps arm; R8 width");
  endtask

  task automatic t_ident;
    expect_rd(3'd2, 32'h5000_0000, "R6 revision field");
    access(1'b1, 3'd2, 32'h1234_5678);
    expect_rd(3'd2, 32'h5000_0000, "R6 ident write ignored");
    expect_rd(3'd4, 32'h0, "R6 ident write no violation");
  endtask

  task automatic t_swreset;
    access(1'b1, 3'd0, KEYV);
    access(1'b1, 3'd1, 32'h8000_00E0);
    check(rst_req === 1'b0, "R7 setting bit gives no request", 32'(rst_req), 0);
    expect_rd(3'd1, 32'h8000_00E0, "R7 reset bit set");
    access(1'b1, 3'd0, KEYV);
    access(1'b1, 3'd1, 32'h0000_00E0);
    check(rst_req === 1'b1, "R7 request after clear", 32'(rst_req), 1);
    @(negedge clk);
    check(rst_req === 1'b0, "R7 request one cycle", 32'(rst_req), 0);
    access(1'b1, 3'd0, KEYV);
    access(1'b1, 3'd1, 32'h0000_00E1);
    check(rst_req === 1'b0, "R7 bit kept low gives no request", 32'(rst_req), 0);
    access(1'b1, 3'd1, 32'h8000_0000);
    access(1'b1, 3'd1, 32'h0000_0000);
    check(rst_req === 1'b0, "R7 locked writes give no request", 32'(rst_req), 0);
    access(1'b1, 3'd4, 32'h1);
  endtask

  task automatic t_unmapped;
    expect_rd(3'd5, 32'h0, "R8 addr 5 reads zero");
    expect_rd(3'd7, 32'h0, "R8 addr 7 reads zero");
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    t_reset();
    t_arm_read();
    t_one_shot();
    t_locked_write();
    t_relock();
    t_ident();
    t_swreset();
    t_unmapped();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule